// File: doc/BRIEF.md
# SD Host Status and Interrupt Unit

This block collects the event and error indications of an SD host controller into one 32-bit status word and turns a selected subset of them into a single interrupt line. One-cycle event pulses come from the command, data, buffer and card-detect logic. Each pulse sets a sticky flag, and software clears that flag by writing a one to its position. Buffer fill state and the card clock-running indication are live levels. They appear in the status word as they arrive, and writes do not touch them.

A simple register port (write strobe, word address, write data, combinational read data) reaches three words. Word 0 is the status word. Word 1 is the interrupt-enable word, whose bit layout differs from the status layout. Word 2 is a read-only revision word. Two extra outputs let the host logic test the outcome of a transfer without decoding bits: one flags any error, the other flags a write that the card never acknowledged with a CRC token.

Top module: `sd_stat_unit`

## Requirements
- R1: After reset all sticky flags, the write-CRC code, and the enable word read 0, and `irq_o` and `wake_o` are low.
- R2: An `ev_i` pulse at a sticky position sets that status bit on the next clock edge, and the bit stays set. The sticky positions are 31, 30, 25, 24, 14, 13, 12, 11, 5, 3, 2, 1 and 0. Pulses at any other position have no effect.
- R3: A write to word 0 clears each sticky flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R4: When an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: Status bits 29, 28, 27, 26, 8, 7 and 6 equal the matching bits of `lvl_i` in the same cycle, and writes to word 0 have no effect on them.
- R6: An event at bit 12 (write done) captures `wcrc_code_i` into status bits [10:9]. Clearing bit 12 without a new event returns the code to 0.
- R7: `err_o` is high exactly when any of status bits [5:0] is set.
- R8: `wr_tmo_o` is high exactly when status bit 2 (write CRC error) is set and the captured code equals 2 (no CRC token).
- R9: Word 1 stores only bits 18..12 and 4..0. All other bits read 0. Word 1 holds its value until it is written again.
- R10: `irq_o` is the OR of these enable/source pairs: en15 with status 31, en14 with status 30, en13 with status 14, en12 with `dat0_i`, en4 with status 7, en3 with status 6, en2 with status 13, en1 with status 12, en0 with status 11.
- R11: `wake_o` is the OR of en18 with status 14, en17 with status 31, and en16 with status 30.
- R12: Word 2 reads 0x400 and ignores writes. Word 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_i | input | 32 | One-cycle event pulses at status bit positions |
| lvl_i | input | 32 | Live level sources at status bit positions |
| wcrc_code_i | input | 2 | Write CRC result code from the data path |
| dat0_i | input | 1 | DAT0 line level |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from addr_i |
| irq_o | output | 1 | Interrupt line |
| wake_o | output | 1 | Wake request |
| err_o | output | 1 | Any error flag set |
| wr_tmo_o | output | 1 | Write CRC error with the no-token code |

## Verification
On every cycle the assertions check the sticky-flag rules: a pulse sets its flag, a clearing write with no pulse empties it, and a flag changes only when a pulse or a clear touches it. They also check that the write-CRC code is zero whenever the write-done flag is clear, that the enable word changes only on a write, and that the interrupt stays low while every enable bit is zero. The bench scenarios cover what a per-cycle property cannot express: the exact mapping of each enable bit to its source, including the wake and DAT0 paths, the masking of enable-word bits, level bits passing through while writes are ignored, how the code is classified as a timeout, and the fixed revision word.

// File: rtl/sd_stat_pkg.sv
package sd_stat_pkg;
  localparam int unsigned DW = 32;
  localparam logic [DW-1:0] STICKY_MASK = 32'hC300_782F;
  localparam logic [DW-1:0] LEVEL_MASK  = 32'h3C00_01C0;
  localparam logic [DW-1:0] EN_MASK     = 32'h0007_F01F;
  localparam int unsigned WR_DONE_BIT = 12;
  localparam int unsigned WCRC_ERR_BIT = 2;
  localparam int unsigned CODE_LSB = 9;
  localparam int unsigned CODE_W = 2;
  localparam logic [CODE_W-1:0] CODE_NO_TOKEN = 2'd2;
  localparam int unsigned ERR_W = 6;
  // enable position -> status position, interrupt sources
  localparam int unsigned IRQ_N = 8;
  localparam int unsigned IRQ_EN_POS [IRQ_N] = '{15, 14, 13, 4, 3, 2, 1, 0};
  localparam int unsigned IRQ_ST_POS [IRQ_N] = '{31, 30, 14, 7, 6, 13, 12, 11};
  localparam int unsigned DAT0_EN_POS = 12;
  // wake sources
  localparam int unsigned WAKE_N = 3;
  localparam int unsigned WAKE_EN_POS [WAKE_N] = '{18, 17, 16};
  localparam int unsigned WAKE_ST_POS [WAKE_N] = '{14, 31, 30};
  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_IEN  = 2'd1,
    REG_REV  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sd_stat_flags.sv
module sd_stat_flags
  import sd_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DW-1:0]     ev_i,
  input  logic [DW-1:0]     clr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [DW-1:0]     flag_o,
  output logic [CODE_W-1:0] code_o
);
  logic [DW-1:0]     flag_q;
  logic [CODE_W-1:0] code_q;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= ((flag_q & ~clr_i) | ev_i) & STICKY_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  code_q <= '0;
    else if (ev_i[WR_DONE_BIT])   code_q <= code_i;
    else if (clr_i[WR_DONE_BIT])  code_q <= '0;
  end

  assign flag_o = flag_q;
  assign code_o = code_q;

  // R2
  ev_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(ev_i) & STICKY_MASK) & ~flag_q) == '0));
  // R3
  w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & $past(clr_i) & ~$past(ev_i)) == '0));
  // R3
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((flag_q ^ $past(flag_q)) & ~($past(ev_i) | $past(clr_i))) == '0));
  // R6
  code_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_q[WR_DONE_BIT] |-> (code_q == '0));
endmodule

// File: rtl/sd_stat_irq.sv
module sd_stat_irq
  import sd_stat_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] status_i,
  input  logic          dat0_i,
  output logic [DW-1:0] en_o,
  output logic          irq_o,
  output logic          wake_o
);
  logic [DW-1:0]     en_q;
  logic [IRQ_N-1:0]  irq_term;
  logic [WAKE_N-1:0] wake_term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (we_i) en_q <= wdata_i & EN_MASK;
  end

  for (genvar i = 0; i < IRQ_N; i++) begin : g_irq
    assign irq_term[i] = en_q[IRQ_EN_POS[i]] & status_i[IRQ_ST_POS[i]];
  end
  for (genvar i = 0; i < WAKE_N; i++) begin : g_wake
    assign wake_term[i] = en_q[WAKE_EN_POS[i]] & status_i[WAKE_ST_POS[i]];
  end

  assign irq_o  = (|irq_term) | (en_q[DAT0_EN_POS] & dat0_i);
  assign wake_o = |wake_term;
  assign en_o   = en_q;

  // R9
  en_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(en_q));
  // R10
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);
  // R11
  wake_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !wake_o);
endmodule

// File: rtl/sd_stat_unit.sv
module sd_stat_unit
  import sd_stat_pkg::*;
#(
  parameter logic [DW-1:0] REV_ID = 32'h0000_0400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DW-1:0]     ev_i,
  input  logic [DW-1:0]     lvl_i,
  input  logic [CODE_W-1:0] wcrc_code_i,
  input  logic              dat0_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o,
  output logic              wake_o,
  output logic              err_o,
  output logic              wr_tmo_o
);
  logic [DW-1:0]     flag;
  logic [DW-1:0]     clr;
  logic [DW-1:0]     status;
  logic [DW-1:0]     en;
  logic [CODE_W-1:0] code;
  logic              we_en;
  reg_sel_e          sel;

  assign sel   = reg_sel_e'(addr_i);
  assign clr   = (we_i && sel == REG_STAT) ? wdata_i : '0;
  assign we_en = we_i && sel == REG_IEN;

  sd_stat_flags u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev_i),
    .clr_i  (clr),
    .code_i (wcrc_code_i),
    .flag_o (flag),
    .code_o (code)
  );

  assign status = flag | (lvl_i & LEVEL_MASK)
                | (DW'(code) << CODE_LSB);

  sd_stat_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_en),
    .wdata_i  (wdata_i),
    .status_i (status),
    .dat0_i   (dat0_i),
    .en_o     (en),
    .irq_o    (irq_o),
    .wake_o   (wake_o)
  );

  assign err_o    = |status[ERR_W-1:0];
  assign wr_tmo_o = status[WCRC_ERR_BIT] && (code == CODE_NO_TOKEN);

  always_comb begin
    unique case (sel)
      REG_STAT: rdata_o = status;
      REG_IEN:  rdata_o = en;
      REG_REV:  rdata_o = REV_ID;
      default:  rdata_o = '0;
    endcase
  end

  // R8
  tmo_needs_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tmo_o |-> err_o);
  // R5
  level_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status ^ lvl_i) & LEVEL_MASK) == '0);
endmodule

// File: tb/sd_stat_unit_bench.sv
`timescale 1ns/1ps
module sd_stat_unit_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] ev = 0, lvl = 0, wdata = 0;
  logic [1:0]  code_in = 0, addr = 0;
  logic        dat0 = 0, we = 0;
  logic [31:0] rdata;
  logic        irq, wake, err, wr_tmo;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sd_stat_unit u_sd_stat_unit (
    .clk_i(clk), .rst_ni(rst_n), .ev_i(ev), .lvl_i(lvl), .wcrc_code_i(code_in),
    .dat0_i(dat0), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .wake_o(wake), .err_o(err), .wr_tmo_o(wr_tmo));

  typedef struct packed {
    logic [31:0] ev;
    logic [31:0] en;
    logic [31:0] st;
    logic        irq;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{32'h8000_0000, 32'h0000_8000, 32'h8000_0000, 1'b1},
    '{32'h4000_0000, 32'h0000_8000, 32'h4000_0000, 1'b0},
    '{32'h0000_2000, 32'h0000_0004, 32'h0000_2000, 1'b1},
    '{32'h0000_0800, 32'h0000_0002, 32'h0000_0800, 1'b0},
    '{32'h0000_1000, 32'h0000_0002, 32'h0000_1000, 1'b1},
    '{32'h0000_003F, 32'h0000_001F, 32'h0000_002F, 1'b0},
    '{32'h3C00_01C0, 32'h0000_001F, 32'h0000_0000, 1'b0},
    '{32'h0000_4000, 32'h0000_2000, 32'h0000_4000, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 0; addr = 0;
  endtask

  task automatic pulse(input logic [31:0] e);
    ev = e;
    @(posedge clk); #1;
    ev = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    rd(0, r); chk("R1 status", r, 0);
    rd(1, r); chk("R1 enable", r, 0);
    chk("R1 irq/wake", {30'd0, irq, wake}, 0);
    rst_n = 1;
    @(posedge clk); #1;

    // table: R2 R5 R10
    for (int i = 0; i < 8; i++) begin
      wr(0, 32'hFFFF_FFFF);
      wr(1, VEC[i].en);
      pulse(VEC[i].ev);
      rd(0, r); chk($sformatf("R2 vec%0d status", i), r, VEC[i].st);
      chk($sformatf("R10 vec%0d irq", i), {31'd0, irq}, {31'd0, VEC[i].irq});
    end

    // R3 writing zero keeps, writing one clears
    wr(0, 32'hFFFF_FFFF); wr(1, 0);
    pulse(32'h0000_6002);
    wr(0, 32'h0);
    rd(0, r); chk("R3 zero write keeps", r, 32'h0000_6002);
    wr(0, 32'h0000_2000);
    rd(0, r); chk("R3 one clears", r, 32'h0000_4002);
    chk("R7 err set", {31'd0, err}, 1);
    wr(0, 32'h0000_0002);
    chk("R7 err clear", {31'd0, err}, 0);

    // R4 same-cycle set and clear
    wr(0, 32'hFFFF_FFFF);
    ev = 32'h0000_2000;
    wr(0, 32'hFFFF_FFFF);
    ev = 0;
    rd(0, r); chk("R4 event wins", r, 32'h0000_2000);

    // R5 level bits pass through and ignore writes
    wr(0, 32'hFFFF_FFFF);
    lvl = 32'hFFFF_FFFF;
    rd(0, r); chk("R5 level follow", r, 32'h3C00_01C0);
    wr(0, 32'hFFFF_FFFF);
    rd(0, r); chk("R5 level ignores write", r, 32'h3C00_01C0);
    wr(1, 32'h0000_0010);
    chk("R10 buffer read ready irq", {31'd0, irq}, 1);
    lvl = 0; #1;
    chk("R10 level gone irq", {31'd0, irq}, 0);

    // R6 R8 write CRC code
    wr(1, 0);
    code_in = 2'd2;
    pulse(32'h0000_1004);
    code_in = 2'd0;
    rd(0, r); chk("R6 code captured", r, 32'h0000_1404);
    chk("R8 no-token timeout", {31'd0, wr_tmo}, 1);
    code_in = 2'd1;
    pulse(32'h0000_1000);
    code_in = 2'd0;
    rd(0, r); chk("R6 code updated", r, 32'h0000_1204);
    chk("R8 other code no timeout", {31'd0, wr_tmo}, 0);
    wr(0, 32'h0000_1000);
    rd(0, r); chk("R6 code cleared", r, 32'h0000_0004);

    // R9 enable mask
    wr(1, 32'hFFFF_FFFF);
    rd(1, r); chk("R9 enable mask", r, 32'h0007_F01F);
    wr(0, 32'h1234_5678);
    rd(1, r); chk("R9 enable holds", r, 32'h0007_F01F);

    // R11 wake, R10 dat0
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'h0002_0000);
    pulse(32'h8000_0000);
    chk("R11 wake on insertion", {30'd0, wake, irq}, 2'b10);
    wr(1, 32'h0001_0000);
    chk("R11 wake removal not set", {31'd0, wake}, 0);
    wr(1, 32'h0000_1000);
    dat0 = 1; #1;
    chk("R10 dat0 irq", {31'd0, irq}, 1);
    dat0 = 0; #1;
    chk("R10 dat0 low", {31'd0, irq}, 0);

    // R12 revision
    rd(2, r); chk("R12 revision", r, 32'h0000_0400);
    wr(2, 32'hFFFF_FFFF);
    rd(2, r); chk("R12 revision read-only", r, 32'h0000_0400);
    rd(3, r); chk("R12 unused word", r, 0);

    // R1 reset mid-run
    wr(1, 32'hFFFF_FFFF);
    pulse(32'h0000_2000);
    rst_n = 0; #1;
    rd(0, r); chk("R1 reset status", r, 0);
    rd(1, r); chk("R1 reset enable", r, 0);
    done = 1;
    finish_run();
  end
endmodule